// File: doc/BRIEF.md
# Fast-Lock Bandwidth Switching Sequencer

This block sits between the register interface of a fractional-N synthesizer and its charge-pump and loop-filter controls. Control words arrive one at a time as an address, a data word and a latch strobe. The frequency word is the commit point. Writes to the auxiliary configuration word and to the modulator phase seed word go only into shadow copies. When the frequency word is written, both shadows move into the active set in the same cycle. The integer and fractional values, the phase seed and a one-cycle modulator load pulse then appear together at the outputs.

Each commit starts a fast-lock sequence. The loop begins in wide-bandwidth mode, with the high charge-pump current selected and the loop-filter switches closed. Two independent timers count reference-clock cycles, each against its own programmed limit. When the first timer expires, the charge-pump current drops to its low setting. When the second expires, the loop-filter switches open. The block runs entirely in the phase-detector reference clock domain. Address map: 0 is the frequency word, 1 is the auxiliary word, 2 is the phase seed, and 3 is unused.

Top module: `fastlock_seq`

## Requirements
- R1: A write to address 0 commits. In the next cycle `freq_int_o` holds data[23:12], `freq_frac_o` holds data[11:0], and `mod_load_o` is high for exactly that one cycle.
- R2: Writes to address 1 or 2 change no output. They only replace the shadow copy of that word.
- R3: On a commit, the shadow auxiliary word and the shadow phase seed (data[11:0] of the last address-2 write) become active together. `phase_seed_o` shows the seed in the same cycle that the new INT and FRAC values appear.
- R4: `cp_wide_o` rises with a commit. It falls exactly max(Tcp,1) reference cycles after the commit edge, where Tcp is bits [9:0] of the committed auxiliary word. It falls at most once per sequence.
- R5: `sw_closed_o` rises with a commit. It falls exactly max(Tsw,1) reference cycles after the commit edge, where Tsw is bits [19:10] of the committed auxiliary word. It falls at most once per sequence.
- R6: `cp_boost_o` equals bit 23 of the committed auxiliary word. A value of 1 requests a 25% higher charge-pump current. The flag stays in force across later commits until a committed auxiliary word has the bit clear.
- R7: A commit during a running sequence restarts both timers from zero. It also drives `cp_wide_o` and `sw_closed_o` high again.
- R8: `busy_o` is high from the commit until both timers have expired, and low otherwise.
- R9: While `rst` is high, and after it is released, every output is zero until the first commit.
- R10: A write to address 3 has no effect on any output or on any shadow word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch strobe, one write per cycle |
| wr_addr | input | 2 | Register select |
| wr_data | input | 24 | Register data |
| freq_int_o | output | 12 | Active integer divide value |
| freq_frac_o | output | 12 | Active fractional value |
| phase_seed_o | output | 12 | Active modulator phase seed |
| mod_load_o | output | 1 | One-cycle modulator load pulse on commit |
| cp_boost_o | output | 1 | Charge-pump +25% adjust flag |
| cp_wide_o | output | 1 | High charge-pump current selected |
| sw_closed_o | output | 1 | Loop-filter switches closed |
| busy_o | output | 1 | Fast-lock sequence in progress |

## Verification
The assertions check several properties on every cycle:
- The active copies hold still unless a commit occurs.
- A commit copies the shadows exactly and puts the loop into wide-bandwidth mode with a load pulse.
- An expired timer stays expired until the next start.
- No counter runs past its limit.

Only the bench's scenarios can show the rest. These are the exact cycle on which each control falls for a given timeout, including the zero-timeout case, and the persistence of the boost flag over commits that do not rewrite it. They also cover restarts in mid-sequence and writes to the unused address.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
  typedef enum logic [1:0] {
    REG_FREQ  = 2'd0,
    REG_AUX   = 2'd1,
    REG_SEED  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_eff;

  // a zero limit behaves like one cycle
  assign lim_eff = (limit == '0) ? CNT_W'(1) : limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (start) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt + CNT_W'(1) >= lim_eff) done <= 1'b1;
      else                            cnt  <= cnt + CNT_W'(1);
    end
  end

  // an expired timer fires only once until restarted (R4, R5)
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  // the running count never reaches the limit (R5)
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    !done |-> (cnt < lim_eff));
endmodule

// File: rtl/fastlock_regs.sv
module fastlock_regs #(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 12,
  parameter int PHASE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit,
  input  logic                     aux_wr,
  input  logic                     seed_wr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-FRAC_W-1:0] act_int,
  output logic [FRAC_W-1:0]        act_frac,
  output logic [DATA_W-1:0]        act_aux,
  output logic [PHASE_W-1:0]       act_seed
);
  logic [DATA_W-1:0]  sh_aux;
  logic [PHASE_W-1:0] sh_seed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_aux  <= '0;
      sh_seed <= '0;
    end else begin
      if (aux_wr)  sh_aux  <= wr_data;
      if (seed_wr) sh_seed <= wr_data[PHASE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_int  <= '0;
      act_frac <= '0;
      act_aux  <= '0;
      act_seed <= '0;
    end else if (commit) begin
      act_int  <= wr_data[DATA_W-1:FRAC_W];
      act_frac <= wr_data[FRAC_W-1:0];
      act_aux  <= sh_aux;
      act_seed <= sh_seed;
    end
  end

  // active set only moves on a commit (R2)
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_aux) && $stable(act_seed) && $stable(act_int) && $stable(act_frac));

  // commit copies both shadows together (R3)
  assert_commit_copy_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (act_aux == $past(sh_aux)) && (act_seed == $past(sh_seed)));
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq #(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 12,
  parameter int PHASE_W = 12,
  parameter int CNT_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-FRAC_W-1:0] freq_int_o,
  output logic [FRAC_W-1:0]        freq_frac_o,
  output logic [PHASE_W-1:0]       phase_seed_o,
  output logic                     mod_load_o,
  output logic                     cp_boost_o,
  output logic                     cp_wide_o,
  output logic                     sw_closed_o,
  output logic                     busy_o
);
  import fastlock_pkg::*;

  localparam int NUM_TMR = 2;
  localparam int BOOST_BIT = DATA_W - 1;

  logic               commit, aux_wr, seed_wr;
  logic [DATA_W-1:0]  act_aux;
  logic [NUM_TMR-1:0] tmr_done;

  assign commit  = wr_en && (wr_addr == REG_FREQ);
  assign aux_wr  = wr_en && (wr_addr == REG_AUX);
  assign seed_wr = wr_en && (wr_addr == REG_SEED);

  fastlock_regs #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)
  ) regs_i (
    .clk(clk), .rst(rst), .commit(commit), .aux_wr(aux_wr), .seed_wr(seed_wr),
    .wr_data(wr_data), .act_int(freq_int_o), .act_frac(freq_frac_o),
    .act_aux(act_aux), .act_seed(phase_seed_o)
  );

  // timer 0: charge-pump current, timer 1: loop-filter switches
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    fastlock_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk(clk), .rst(rst), .start(commit),
      .limit(act_aux_lim(i)), .done(tmr_done[i])
    );
  end

  // limits come from the incoming shadow on a commit cycle via the active copy next cycle;
  // the timer only reads its limit while running, after the copy has landed
  function automatic logic [CNT_W-1:0] act_aux_lim(input int idx);
    return act_aux[idx*CNT_W +: CNT_W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) mod_load_o <= 1'b0;
    else     mod_load_o <= commit;
  end

  assign cp_boost_o  = act_aux[BOOST_BIT];
  assign cp_wide_o   = ~tmr_done[0];
  assign sw_closed_o = ~tmr_done[1];
  assign busy_o      = ~&tmr_done;

  // commit puts the loop in wide mode and pulses the load (R1, R7)
  assert_commit_wide_R7: assert property (@(posedge clk) disable iff (rst)
    commit |=> mod_load_o && cp_wide_o && sw_closed_o && busy_o);

  // load pulse only follows a commit (R1)
  assert_load_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    !commit |=> !mod_load_o);
endmodule

// File: tb/fastlock_seq_tb.sv
module fastlock_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [23:0] wr_data = '0;
  logic [11:0] freq_int_o, freq_frac_o, phase_seed_o;
  logic        mod_load_o, cp_boost_o, cp_wide_o, sw_closed_o, busy_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  // bench model state
  logic [23:0] m_sh_aux, m_act_aux;
  logic [11:0] m_sh_seed, m_act_seed, m_int, m_frac;
  bit          m_seq, m_load;
  int          m_k;

  fastlock_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_int_o(freq_int_o), .freq_frac_o(freq_frac_o), .phase_seed_o(phase_seed_o),
    .mod_load_o(mod_load_o), .cp_boost_o(cp_boost_o), .cp_wide_o(cp_wide_o),
    .sw_closed_o(sw_closed_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  function automatic int lim(input logic [9:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic model_reset();
    m_sh_aux = '0; m_act_aux = '0; m_sh_seed = '0; m_act_seed = '0;
    m_int = '0; m_frac = '0; m_seq = 0; m_load = 0; m_k = 0;
  endtask

  task automatic model_edge(input bit we, input logic [1:0] a, input logic [23:0] d);
    m_load = 0;
    if (we && a == 2'd0) begin
      m_int = d[23:12]; m_frac = d[11:0];
      m_act_aux = m_sh_aux; m_act_seed = m_sh_seed;
      m_seq = 1; m_k = 0; m_load = 1;
    end else begin
      if (m_seq && m_k < 100000) m_k++;
      if (we && a == 2'd1) m_sh_aux = d;
      if (we && a == 2'd2) m_sh_seed = d[11:0];
    end
  endtask

  task automatic compare_all();
    bit ew, es;
    ew = m_seq && (m_k < lim(m_act_aux[9:0]));
    es = m_seq && (m_k < lim(m_act_aux[19:10]));
    chk("R1 int",   freq_int_o,   m_int);
    chk("R1 frac",  freq_frac_o,  m_frac);
    chk("R1 load",  mod_load_o,   m_load);
    chk("R3 seed",  phase_seed_o, m_act_seed);
    chk("R4 cp",    cp_wide_o,    ew);
    chk("R5 sw",    sw_closed_o,  es);
    chk("R6 boost", cp_boost_o,   m_act_aux[23]);
    chk("R8 busy",  busy_o,       ew || es);
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [23:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0);
  endtask

  function automatic logic [23:0] aux_word(input bit boost, input int tsw, input int tcp);
    return {boost, 3'b000, 10'(tsw), 10'(tcp)};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk("R9 reset", {freq_int_o, freq_frac_o, phase_seed_o, mod_load_o, cp_boost_o,
                     cp_wide_o, sw_closed_o, busy_o}, '0);
    rst = 0;
    idle(2);
    chk("R9 idle busy", busy_o, 0);

    // R2/R3: shadow writes invisible until commit
    step(1, 2'd1, aux_word(1, 7, 4));
    step(1, 2'd2, 24'h000abc);
    chk("R2 seed held", phase_seed_o, 12'h000);
    chk("R2 boost held", cp_boost_o, 0);
    step(1, 2'd0, 24'h123456);
    chk("R3 seed commit", phase_seed_o, 12'habc);
    idle(10);
    // R6: boost survives a commit without new aux
    step(1, 2'd0, 24'h00f001);
    chk("R6 boost kept", cp_boost_o, 1);
    idle(9);
    // R10: address 3 ignored
    step(1, 2'd3, 24'hffffff);
    idle(2);
    step(1, 2'd0, 24'h222222);
    chk("R10 spare ignored", cp_boost_o, 1);
    idle(10);
    // zero timeouts and clearing the boost (R4, R5, R6)
    step(1, 2'd1, aux_word(0, 0, 0));
    step(1, 2'd0, 24'h333333);
    idle(3);
    chk("R6 boost cleared", cp_boost_o, 0);
    // R7: restart mid-sequence
    step(1, 2'd1, aux_word(0, 20, 12));
    step(1, 2'd0, 24'h444444);
    idle(8);
    step(1, 2'd0, 24'h555555);
    chk("R7 restart wide", cp_wide_o & sw_closed_o, 1);
    idle(25);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [23:0] d;
      r = $urandom_range(0, 99);
      d = $urandom();
      if (r < 3)       step(1, 2'd0, d);
      else if (r < 6)  step(1, 2'd1, aux_word(d[23], $urandom_range(0, 40), $urandom_range(0, 40)));
      else if (r < 9)  step(1, 2'd2, d);
      else if (r < 10) step(1, 2'd3, d);
      else             step(0, 2'($urandom_range(0, 3)), d);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule